// File: doc/BRIEF.md
# Dual-Port Scan Path State Register

This block is the state register of a sequential circuit, built so that it can double as a serial shift register for test. Every bit is a flip-flop with two data paths. The functional path takes the next-state value from the surrounding combinational logic. The scan path takes the output of the neighbouring bit. Each path has its own clock enable, and both enables act on one shared clock.

In normal operation, the system enable loads the parallel next-state vector in one cycle. In test, the test enable moves the bits one step along the chain per cycle. Data enters bit 0 from the serial input, and the most significant bit drives the serial output. A typical test shifts a chosen state in, applies the primary inputs, pulses the system enable once, and then shifts the resulting state out.

Top module: `dual_port_state_reg`

## Requirements
- R1: When `rst` is high at a clock edge, every bit of `state_q` becomes 0 at that edge, whatever the enables are.
- R2: When `sys_en` is 1 and `tst_en` is 0 at an edge, `state_q` takes the value of `nxt_state` at that edge.
- R3: When `tst_en` is 1 at an edge, bit 0 takes `scan_in` and each bit i>0 takes the old bit i-1, so the state becomes {old[W-2:0], scan_in}.
- R4: `scan_out` always equals the most significant bit of `state_q`. After a shift it therefore shows the old bit W-2.
- R5: When `sys_en` and `tst_en` are both 1, the shift of R3 is performed and `nxt_state` has no effect.
- R6: When both enables are 0, `state_q` keeps its value and `nxt_state` and `scan_in` have no effect.
- R7: The full test sequence works end to end. After W shift cycles, the bit shifted in first sits in bit W-1. A single system cycle then loads the next state. Reading `scan_out` before each of W further shifts returns that next state, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both load paths |
| rst | input | 1 | Synchronous active-high reset to the all-zero state |
| sys_en | input | 1 | System (functional) load enable |
| tst_en | input | 1 | Test (scan) shift enable; wins over `sys_en` |
| nxt_state | input | CHAIN_LEN | Next-state value from the combinational logic |
| scan_in | input | 1 | Serial data entering bit 0 |
| state_q | output | CHAIN_LEN | Current register contents |
| scan_out | output | 1 | Serial data leaving the chain (bit CHAIN_LEN-1) |

## Verification
The assertions check every cycle that a shift moves the head and body of the chain by one position and that the serial output follows the old bit W-2. They also check that a system-only cycle loads the next-state input, that an idle cycle holds the state, and that reset clears the register. Two things can only be shown by the bench's scenarios: the priority of the shift when both enables are high, and the complete shift-in, capture and shift-out test sequence with its bit ordering.

// File: rtl/dpsr_pkg.sv
package dpsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_CLEAR = 2'd3
  } cell_op_e;
endpackage

// File: rtl/dpsr_mode_sel.sv
module dpsr_mode_sel
  import dpsr_pkg::*;
(
  input  logic     rst,
  input  logic     sys_en,
  input  logic     tst_en,
  output cell_op_e op
);
  // Priority: reset, then test shift, then functional load.
  always_comb begin
    if (rst)         op = OP_CLEAR;
    else if (tst_en) op = OP_SHIFT;
    else if (sys_en) op = OP_LOAD;
    else             op = OP_HOLD;
  end
endmodule

// File: rtl/dpsr_cell.sv
module dpsr_cell
  import dpsr_pkg::*;
(
  input  logic     clk,
  input  cell_op_e op,
  input  logic     d_func,
  input  logic     d_scan,
  output logic     q
);
  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q <= 1'b0;
      OP_SHIFT: q <= d_scan;
      OP_LOAD:  q <= d_func;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/dual_port_state_reg.sv
module dual_port_state_reg
  import dpsr_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sys_en,
  input  logic                 tst_en,
  input  logic [CHAIN_LEN-1:0] nxt_state,
  input  logic                 scan_in,
  output logic [CHAIN_LEN-1:0] state_q,
  output logic                 scan_out
);
  localparam int MSB = CHAIN_LEN - 1;

  cell_op_e             op;
  logic [CHAIN_LEN-1:0] scan_link;

  dpsr_mode_sel u_mode (
    .rst    (rst),
    .sys_en (sys_en),
    .tst_en (tst_en),
    .op     (op)
  );

  genvar i;
  generate
    for (i = 0; i < CHAIN_LEN; i++) begin : g_bit
      if (i == 0) begin : g_head
        assign scan_link[i] = scan_in;
      end else begin : g_body
        assign scan_link[i] = state_q[i-1];
      end
      dpsr_cell u_cell (
        .clk    (clk),
        .op     (op),
        .d_func (nxt_state[i]),
        .d_scan (scan_link[i]),
        .q      (state_q[i])
      );
    end
  endgenerate

  assign scan_out = state_q[MSB];

  // Assertions
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state_q == '0)); // R1

  AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (sys_en && !tst_en) |=> (state_q == $past(nxt_state))); // R2

  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
    tst_en |=> (state_q[0] == $past(scan_in))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sys_en && !tst_en) |=> $stable(state_q)); // R6

  generate
    if (CHAIN_LEN > 1) begin : g_chain_chk
      AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (rst)
        tst_en |=> (state_q[MSB:1] == $past(state_q[MSB-1:0]))); // R3
      AST_SERIAL_OUT: assert property (@(posedge clk) disable iff (rst)
        tst_en |=> (scan_out == $past(state_q[MSB-1]))); // R4
    end
  endgenerate
endmodule

// File: tb/dual_port_state_reg_test.sv
module dual_port_state_reg_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sys_en = 1'b0;
  logic         tst_en = 1'b0;
  logic [W-1:0] nxt_state = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] state_q;
  logic         scan_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dual_port_state_reg #(.CHAIN_LEN(W)) uut (
    .clk(clk), .rst(rst), .sys_en(sys_en), .tst_en(tst_en),
    .nxt_state(nxt_state), .scan_in(scan_in),
    .state_q(state_q), .scan_out(scan_out)
  );

  typedef struct packed {
    logic         r;
    logic         s;
    logic         t;
    logic         si;
    logic [W-1:0] nxt;
    logic [W-1:0] exp_q;
    logic         exp_so;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,8'hA5,8'hA5,1'b1,4'd2}, // R2 load
    '{1'b0,1'b0,1'b0,1'b1,8'hFF,8'hA5,1'b1,4'd6}, // R6 hold
    '{1'b0,1'b0,1'b1,1'b0,8'h00,8'h4A,1'b0,4'd3}, // R3 shift 0
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h95,1'b1,4'd3}, // R3 shift 1
    '{1'b0,1'b1,1'b1,1'b0,8'h00,8'h2A,1'b0,4'd5}, // R5 shift wins
    '{1'b0,1'b1,1'b0,1'b0,8'h3C,8'h3C,1'b0,4'd2}, // R2 load
    '{1'b0,1'b0,1'b1,1'b1,8'hFF,8'h79,1'b0,4'd3}, // R3 shift 1
    '{1'b1,1'b1,1'b0,1'b0,8'hFF,8'h00,1'b0,4'd1}  // R1 reset beats load
  };

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic r, logic s, logic t, logic si, logic [W-1:0] nx);
    rst = r; sys_en = s; tst_en = t; scan_in = si; nxt_state = nx;
    @(negedge clk);
  endtask

  localparam logic [W-1:0] SHIFT_PAT = 8'hC3;
  localparam logic [W-1:0] CAPT_PAT  = 8'h5A;

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", state_q, '0);
    check("R4 reset serial out", {{(W-1){1'b0}}, scan_out}, '0);

    foreach (TBL[k]) begin
      drive(TBL[k].r, TBL[k].s, TBL[k].t, TBL[k].si, TBL[k].nxt);
      check($sformatf("R%0d vector %0d state", TBL[k].req, k), state_q, TBL[k].exp_q);
      check($sformatf("R4 vector %0d scan_out", k),
            {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, TBL[k].exp_so});
    end

    // R7: full test sequence, shift in MSB first, capture, shift out.
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0);
    for (int b = W-1; b >= 0; b--) drive(1'b0, 1'b0, 1'b1, SHIFT_PAT[b], 8'hFF);
    check("R7 state after shift-in", state_q, SHIFT_PAT);
    drive(1'b0, 1'b1, 1'b0, 1'b1, CAPT_PAT);
    check("R7 state after capture", state_q, CAPT_PAT);
    for (int b = W-1; b >= 0; b--) begin
      check($sformatf("R7 shift-out bit %0d", b),
            {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, CAPT_PAT[b]});
      drive(1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
    end
    check("R7 chain empty after shift-out", state_q, '0);

    // R6: idle with toggling inputs.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h81);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h7E);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R6 idle keeps value", state_q, 8'h81);

    // R5: both enables with a next-state that would differ.
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    check("R5 both enables shift", state_q, 8'h03);
    check("R4 serial out after shift", {{(W-1){1'b0}}, scan_out}, '0);

    // R1: reset during shift.
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF);
    check("R1 reset beats shift", state_q, '0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule